// File: doc/BRIEF.md
# Translation Fault Register Updater

This block sits beside an address translator and records what went wrong when a translation fails. Each cycle the translator may present a fault strobe with a fault class, the virtual address that missed, and whether the access was a store. On a strobe the block picks a 5-bit exception cause code and loads three fault-reporting registers in one clock. The bad-address register takes the whole address. The page-table context register keeps its software-owned base field and receives the address's page-pair number in a shifted slot. The translation-entry high register keeps its address-space identifier and receives the page-pair number in its upper bits.

One cycle after the strobe the block raises a single-cycle exception request that carries the cause code. A small register port lets software read all three registers and rewrite the context and entry-high registers, for example to set the page-table base or the current address-space identifier. When a fault and a software write arrive in the same cycle, the fault update wins.

Top module: `xlat_fault_reporter`

## Requirements
- R1: Fault class 0 (address error) yields cause code 5 for a store (`flt_write`=1) and code 4 for a load.
- R2: Fault classes 1 (no matching entry) and 2 (entry present but not valid) yield cause code 3 for a store and code 2 for a load.
- R3: Fault class 3 (store to a clean page) yields cause code 1 whatever the value of `flt_write`.
- R4: On a fault the bad-address register (select 0) holds the full 32-bit faulting address from the next edge on. Without a fault it keeps its value, and a software write to select 0 is ignored.
- R5: On a fault the context register (select 1) becomes (old AND 0xFF800000) OR ((address >> 9) AND 0x007FFFF0). Its bits 31:23 are kept, bits 22:4 take address bits 31:13, and bits 3:0 are cleared.
- R6: On a fault the entry-high register (select 2) becomes (old AND 0x000000FF) OR (address AND 0xFFFFE000). The identifier in bits 7:0 is kept, bits 31:13 take the address page-pair number, and bits 12:8 are cleared.
- R7: `exc_req` is high for exactly the cycle after each cycle in which `flt_valid` was sampled high, so back-to-back faults give back-to-back pulses. `exc_code` then shows that fault's cause code.
- R8: `csr_rdata` combinationally shows the register picked by `csr_sel` (0 bad address, 1 context, 2 entry high), and select 3 reads zero. With `csr_we` high and no fault, a full 32-bit write to select 1 or 2 takes effect at the next edge.
- R9: If `flt_valid` and `csr_we` are both high in one cycle, the fault update is applied to all three registers and the software write is discarded.
- R10: While reset is active, and after its release, all three registers read zero and `exc_req` is low until the first fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flt_valid | input | 1 | Fault strobe from the translator |
| flt_class | input | 2 | Fault class: 0 address error, 1 no match, 2 invalid, 3 clean-page store |
| flt_write | input | 1 | 1 when the faulting access was a store |
| flt_addr | input | 32 | Faulting virtual address |
| csr_sel | input | 2 | Register select: 0 bad address, 1 context, 2 entry high |
| csr_we | input | 1 | Software write enable |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Read data for the selected register |
| exc_req | output | 1 | One-cycle exception request |
| exc_code | output | 5 | Cause code accompanying the request |

## Verification
The bench writes non-zero patterns into the context base and the entry-high identifier before faulting, so a merge that clears or overwrites the kept fields shows up as a wrong read-back. A merge that shifts the page-pair slice by one bit, or leaves the low bits set, also gives a wrong value. The bench drives every class in both directions. A design that lets the store flag affect the clean-page code, or swaps the load and store codes, reports the wrong cause on the request. The bench also drives back-to-back faults and a fault coincident with a software write to the context register. A design that stretches or merges request pulses, or lets the software write win, leaves an unmatched or missing request or a stale register value. A write to the bad-address select must leave the register unchanged.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

  typedef enum logic [1:0] {
    FLT_ADDR_ERR = 2'd0,
    FLT_NO_MATCH = 2'd1,
    FLT_INVALID  = 2'd2,
    FLT_CLEAN_WR = 2'd3
  } flt_class_e;

  typedef enum logic [1:0] {
    SEL_BADADDR = 2'd0,
    SEL_CONTEXT = 2'd1,
    SEL_ENTRYHI = 2'd2,
    SEL_NONE    = 2'd3
  } csr_sel_e;

  localparam int unsigned CODE_W = 5;

  localparam logic [CODE_W-1:0] CAUSE_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] CAUSE_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] CAUSE_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] CAUSE_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] CAUSE_ADES = 5'd5;

endpackage

// File: rtl/xfr_rst_sync.sv
module xfr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/xfr_cause_sel.sv
module xfr_cause_sel
  import xfr_pkg::*;
(
  input  logic [1:0]        flt_class,
  input  logic              flt_write,
  output logic [CODE_W-1:0] cause
);
  flt_class_e cls;
  assign cls = flt_class_e'(flt_class);

  always_comb begin
    unique case (cls)
      FLT_ADDR_ERR: cause = flt_write ? CAUSE_ADES : CAUSE_ADEL;
      FLT_NO_MATCH,
      FLT_INVALID:  cause = flt_write ? CAUSE_TLBS : CAUSE_TLBL;
      FLT_CLEAN_WR: cause = CAUSE_MOD;
      default:      cause = CAUSE_MOD;
    endcase
  end
endmodule

// File: rtl/xfr_field_merge.sv
module xfr_field_merge #(
  parameter int unsigned VA_W          = 32,
  parameter int unsigned ASID_W        = 8,
  parameter int unsigned PAIR_LSB      = 13,
  parameter int unsigned CTX_FIELD_LSB = 4,
  localparam int unsigned VPN_W        = VA_W - PAIR_LSB,
  localparam int unsigned CTX_BASE_LSB = CTX_FIELD_LSB + VPN_W,
  localparam int unsigned CTX_BASE_W   = VA_W - CTX_BASE_LSB
) (
  input  logic [VPN_W-1:0]      vpn_pair,
  input  logic [CTX_BASE_W-1:0] ctx_base,
  input  logic [ASID_W-1:0]     asid,
  output logic [VA_W-1:0]       ctx_new,
  output logic [VA_W-1:0]       ehi_new
);
  // Context: kept base on top, page-pair number below it, zeros at the bottom
  always_comb begin
    ctx_new = '0;
    ctx_new[VA_W-1:CTX_BASE_LSB]          = ctx_base;
    ctx_new[CTX_BASE_LSB-1:CTX_FIELD_LSB] = vpn_pair;
  end

  // Entry high: page-pair number on top, zero gap, kept identifier at the bottom
  always_comb begin
    ehi_new = '0;
    ehi_new[VA_W-1:PAIR_LSB] = vpn_pair;
    ehi_new[ASID_W-1:0]      = asid;
  end
endmodule

// File: rtl/xfr_read_mux.sv
module xfr_read_mux
  import xfr_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  logic [1:0]      csr_sel,
  input  logic [VA_W-1:0] badv,
  input  logic [VA_W-1:0] ctx,
  input  logic [VA_W-1:0] ehi,
  output logic [VA_W-1:0] rdata
);
  csr_sel_e sel;
  assign sel = csr_sel_e'(csr_sel);

  always_comb begin
    unique case (sel)
      SEL_BADADDR: rdata = badv;
      SEL_CONTEXT: rdata = ctx;
      SEL_ENTRYHI: rdata = ehi;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlat_fault_reporter.sv
module xlat_fault_reporter
  import xfr_pkg::*;
#(
  parameter int unsigned VA_W          = 32,
  parameter int unsigned ASID_W        = 8,
  parameter int unsigned PAIR_LSB      = 13,
  parameter int unsigned CTX_FIELD_LSB = 4,
  localparam int unsigned VPN_W        = VA_W - PAIR_LSB,
  localparam int unsigned CTX_BASE_LSB = CTX_FIELD_LSB + VPN_W,
  localparam int unsigned CTX_BASE_W   = VA_W - CTX_BASE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [1:0]        flt_class,
  input  logic              flt_write,
  input  logic [VA_W-1:0]   flt_addr,
  input  logic [1:0]        csr_sel,
  input  logic              csr_we,
  input  logic [VA_W-1:0]   csr_wdata,
  output logic [VA_W-1:0]   csr_rdata,
  output logic              exc_req,
  output logic [CODE_W-1:0] exc_code
);
  logic rst_n_sync;

  logic [VA_W-1:0]   badv_q, badv_d;
  logic [VA_W-1:0]   ctx_q,  ctx_d;
  logic [VA_W-1:0]   ehi_q,  ehi_d;
  logic              req_q,  req_d;
  logic [CODE_W-1:0] code_q, code_d;

  logic [CODE_W-1:0] cause;
  logic [VA_W-1:0]   ctx_flt, ehi_flt;
  logic              ctx_wr, ehi_wr;

  xfr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xfr_cause_sel u_cause (
    .flt_class (flt_class),
    .flt_write (flt_write),
    .cause     (cause)
  );

  xfr_field_merge #(
    .VA_W          (VA_W),
    .ASID_W        (ASID_W),
    .PAIR_LSB      (PAIR_LSB),
    .CTX_FIELD_LSB (CTX_FIELD_LSB)
  ) u_merge (
    .vpn_pair (flt_addr[VA_W-1:PAIR_LSB]),
    .ctx_base (ctx_q[VA_W-1:CTX_BASE_LSB]),
    .asid     (ehi_q[ASID_W-1:0]),
    .ctx_new  (ctx_flt),
    .ehi_new  (ehi_flt)
  );

  xfr_read_mux #(.VA_W(VA_W)) u_rmux (
    .csr_sel (csr_sel),
    .badv    (badv_q),
    .ctx     (ctx_q),
    .ehi     (ehi_q),
    .rdata   (csr_rdata)
  );

  // Software write enables; the bad-address register has none
  assign ctx_wr = csr_we && (csr_sel_e'(csr_sel) == SEL_CONTEXT);
  assign ehi_wr = csr_we && (csr_sel_e'(csr_sel) == SEL_ENTRYHI);

  // Next state: a fault takes priority over any software write
  always_comb begin
    badv_d = badv_q;
    ctx_d  = ctx_q;
    ehi_d  = ehi_q;
    code_d = code_q;
    req_d  = flt_valid;
    if (flt_valid) begin
      badv_d = flt_addr;
      ctx_d  = ctx_flt;
      ehi_d  = ehi_flt;
      code_d = cause;
    end else begin
      if (ctx_wr) ctx_d = csr_wdata;
      if (ehi_wr) ehi_d = csr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      badv_q <= '0;
      ctx_q  <= '0;
      ehi_q  <= '0;
      req_q  <= 1'b0;
      code_q <= '0;
    end else begin
      badv_q <= badv_d;
      ctx_q  <= ctx_d;
      ehi_q  <= ehi_d;
      req_q  <= req_d;
      code_q <= code_d;
    end
  end

  assign exc_req  = req_q;
  assign exc_code = code_q;
endmodule

// File: rtl/xfr_checker.sv
module xfr_checker #(
  parameter int unsigned VA_W          = 32,
  parameter int unsigned ASID_W        = 8,
  parameter int unsigned PAIR_LSB      = 13,
  parameter int unsigned CTX_FIELD_LSB = 4,
  localparam int unsigned VPN_W        = VA_W - PAIR_LSB,
  localparam int unsigned CTX_BASE_LSB = CTX_FIELD_LSB + VPN_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flt_valid,
  input logic [1:0]      flt_class,
  input logic            flt_write,
  input logic [VA_W-1:0] flt_addr,
  input logic            csr_we,
  input logic [VA_W-1:0] badv,
  input logic [VA_W-1:0] ctx,
  input logic [VA_W-1:0] ehi,
  input logic            exc_req,
  input logic [4:0]      exc_code
);
  p_clean_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_class == 2'd3) |=> (exc_code == 5'd1));

  p_addr_err_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_class == 2'd0) |=> (exc_code == (flt_write_d ? 5'd5 : 5'd4)));

  p_badv_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (badv == $past(flt_addr)));

  p_badv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> $stable(badv));

  p_ctx_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (ctx[VA_W-1:CTX_BASE_LSB] == $past(ctx[VA_W-1:CTX_BASE_LSB]))
              && (ctx[CTX_BASE_LSB-1:CTX_FIELD_LSB] == $past(flt_addr[VA_W-1:PAIR_LSB]))
              && (ctx[CTX_FIELD_LSB-1:0] == '0));

  p_ehi_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (ehi[ASID_W-1:0] == $past(ehi[ASID_W-1:0]))
              && (ehi[VA_W-1:PAIR_LSB] == $past(flt_addr[VA_W-1:PAIR_LSB]))
              && (ehi[PAIR_LSB-1:ASID_W] == '0));

  p_req_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> exc_req);

  p_req_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> !exc_req);

  p_fault_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && csr_we) |=> (ctx[CTX_FIELD_LSB-1:0] == '0) && (badv == $past(flt_addr)));

  // store flag delayed one cycle for R1 code check
  logic flt_write_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_write_d <= 1'b0;
    else        flt_write_d <= flt_write;
  end
endmodule

bind xlat_fault_reporter xfr_checker #(
  .VA_W          (VA_W),
  .ASID_W        (ASID_W),
  .PAIR_LSB      (PAIR_LSB),
  .CTX_FIELD_LSB (CTX_FIELD_LSB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .flt_valid (flt_valid),
  .flt_class (flt_class),
  .flt_write (flt_write),
  .flt_addr  (flt_addr),
  .csr_we    (csr_we),
  .badv      (badv_q),
  .ctx       (ctx_q),
  .ehi       (ehi_q),
  .exc_req   (exc_req),
  .exc_code  (exc_code)
);

// File: tb/tb_xlat_fault_reporter.sv
`timescale 1ns/1ps
module tb_xlat_fault_reporter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flt_valid;
  logic [1:0]  flt_class;
  logic        flt_write;
  logic [31:0] flt_addr;
  logic [1:0]  csr_sel;
  logic        csr_we;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        exc_req;
  logic [4:0]  exc_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct { logic [4:0] code; string tag; } exp_t;
  exp_t exp_q[$];

  logic [31:0] m_badv, m_ctx, m_ehi;

  always #2.5 clk = ~clk;

  xlat_fault_reporter dut (
    .clk, .rst_n, .flt_valid, .flt_class, .flt_write, .flt_addr,
    .csr_sel, .csr_we, .csr_wdata, .csr_rdata, .exc_req, .exc_code
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_code(input logic [1:0] c, input logic w);
    case (c)
      2'd0:    return w ? 5'd5 : 5'd4;
      2'd1,
      2'd2:    return w ? 5'd3 : 5'd2;
      default: return 5'd1;
    endcase
  endfunction

  function automatic string code_tag(input logic [1:0] c);
    case (c)
      2'd0:    return "R1 code";
      2'd3:    return "R3 code";
      default: return "R2 code";
    endcase
  endfunction

  // Model update for a fault (R4, R5, R6)
  task automatic model_fault(input logic [1:0] c, input logic w, input logic [31:0] a);
    exp_t e;
    m_badv = a;
    m_ctx  = (m_ctx & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
    m_ehi  = (m_ehi & 32'h0000_00FF) | (a & 32'hFFFF_E000);
    e.code = exp_code(c, w);
    e.tag  = code_tag(c);
    exp_q.push_back(e);
  endtask

  // Drive a fault for one cycle, optionally with a coincident software write
  task automatic fault(input logic [1:0] c, input logic w, input logic [31:0] a,
                       input logic we, input logic [1:0] sel, input logic [31:0] wd);
    @(posedge clk); #1;
    flt_valid = 1'b1; flt_class = c; flt_write = w; flt_addr = a;
    csr_we = we; csr_sel = sel; csr_wdata = wd;
    model_fault(c, w, a);
    @(posedge clk); #1;
    flt_valid = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] wd);
    @(posedge clk); #1;
    csr_we = 1'b1; csr_sel = sel; csr_wdata = wd;
    if (sel == 2'd1) m_ctx = wd;
    if (sel == 2'd2) m_ehi = wd;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic read_all(input string tag);
    csr_sel = 2'd0; #0.2; check({tag, " R4 badaddr"}, csr_rdata, m_badv);
    csr_sel = 2'd1; #0.2; check({tag, " R5 context"}, csr_rdata, m_ctx);
    csr_sel = 2'd2; #0.2; check({tag, " R6 entryhi"}, csr_rdata, m_ehi);
    csr_sel = 2'd3; #0.2; check({tag, " R8 sel3"},    csr_rdata, 32'h0);
  endtask

  // Monitor: pops one expected cause per request pulse (R7)
  always @(negedge clk) begin
    if (rst_n && exc_req) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected request: actual exc_req 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " R7 pulse"}, {27'd0, exc_code}, {27'd0, e.code});
      end
    end
  end

  initial begin
    rst_n = 1'b0; flt_valid = 1'b0; flt_class = 2'd0; flt_write = 1'b0;
    flt_addr = '0; csr_sel = 2'd0; csr_we = 1'b0; csr_wdata = '0;
    m_badv = '0; m_ctx = '0; m_ehi = '0;
    repeat (3) @(posedge clk);
    #1;
    read_all("R10 in reset");
    check("R10 req in reset", {31'd0, exc_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    read_all("R10 after release");
    check("R10 req after release", {31'd0, exc_req}, 32'd0);

    // R8: software sets context base and identifier
    csr_write(2'd1, 32'hABC0_000F);
    csr_write(2'd2, 32'h0000_1F5A);
    read_all("R8 writes");

    // R4: write to bad-address select ignored
    csr_write(2'd0, 32'hDEAD_BEEF);
    csr_sel = 2'd0; #0.2; check("R4 ignored write", csr_rdata, 32'h0);

    // R1, R2, R3 across classes and directions with merges (R5, R6)
    fault(2'd0, 1'b0, 32'h8000_1234, 1'b0, 2'd0, '0); read_all("R1 load");
    fault(2'd0, 1'b1, 32'hFFFF_FFFF, 1'b0, 2'd0, '0); read_all("R1 store");
    fault(2'd1, 1'b0, 32'h0040_2ABC, 1'b0, 2'd0, '0); read_all("R2 nomatch load");
    fault(2'd1, 1'b1, 32'h7FFF_E000, 1'b0, 2'd0, '0); read_all("R2 nomatch store");
    fault(2'd2, 1'b0, 32'h1234_5678, 1'b0, 2'd0, '0); read_all("R2 invalid load");
    fault(2'd2, 1'b1, 32'hC000_3FFF, 1'b0, 2'd0, '0); read_all("R2 invalid store");
    fault(2'd3, 1'b1, 32'h0000_2001, 1'b0, 2'd0, '0); read_all("R3 store");
    fault(2'd3, 1'b0, 32'hA5A5_A5A5, 1'b0, 2'd0, '0); read_all("R3 load flag");

    // R5/R6 with new kept fields after a fault
    csr_write(2'd1, 32'hFFFF_FFFF);
    csr_write(2'd2, 32'hFFFF_FFFF);
    fault(2'd1, 1'b0, 32'h5555_5555, 1'b0, 2'd0, '0); read_all("R5 R6 kept fields");

    // R9: fault collides with a context write
    fault(2'd2, 1'b1, 32'h0002_4000, 1'b1, 2'd1, 32'h1111_1111); read_all("R9 collide ctx");
    fault(2'd0, 1'b0, 32'h9999_0000, 1'b1, 2'd2, 32'h2222_2222); read_all("R9 collide ehi");

    // R7: back-to-back faults give two adjacent pulses
    @(posedge clk); #1;
    flt_valid = 1'b1; flt_class = 2'd1; flt_write = 1'b1; flt_addr = 32'h0101_0101;
    model_fault(2'd1, 1'b1, 32'h0101_0101);
    @(posedge clk); #1;
    flt_class = 2'd3; flt_write = 1'b0; flt_addr = 32'hF0F0_F0F0;
    model_fault(2'd3, 1'b0, 32'hF0F0_F0F0);
    @(posedge clk); #1;
    flt_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    read_all("R7 burst");
    check("R7 all pulses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule